// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block switches five supply rails of a display power unit on and off in a fixed order. A power-up starts only when three conditions hold: the chip enable is high, the filtered input-supply-good level is high, and no over-temperature fault is present. The block then turns on an internal reference. After a settle time it turns on the rails one at a time, from the most negative rail to the most positive. If any start condition is lost, the rails that are on are switched off in reverse order. Each switch-off is followed by a minimum discharge wait before the next one.

All delays are counted on a one-millisecond tick supplied from outside. A delay of N ticks is held in a down-counter that is loaded with N and decreased on each tick. The raw supply-good input passes through a level filter before it is used. A short dip on that input therefore does not stop the rails.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted and right after it, all five rail enables, the reference enable, `all_up_o` and `busy_o` are 0.
- R2: A sequence starts only when `chip_en_i` is high, the filtered supply-good level is high and `therm_fault_i` is low. While the fault is held, the block stays idle with the reference off, even if enable and supply are good.
- R3: The filtered supply-good level takes a new value only after `DEB_TICKS` consecutive ticks in which the raw input has differed from it. A dip shorter than that has no effect on the rails.
- R4: A start turns the reference on in the cycle after the filtered level qualifies. Gate-low turns on `T_REF` ticks later, and each following rail turns on `T_STEP` ticks after the previous one. Bit mapping of `rail_en_o`: [0] gate-low, [1] negative source, [2] bias, [3] gate-high, [4] positive source. The order of turn-on is bit 0 up to bit 4.
- R5: `all_up_o` is 1 exactly while all five rails are on and no sequence is running. `busy_o` is 1 during both the power-up and the power-down sequence.
- R6: Power-down removes rails from bit 4 down to bit 0. The first rail goes off on the second clock edge after enable or the fault changes at an edge.
- R7: After each rail is removed, the block waits a minimum number of ticks before the next step. The wait is `T_SHORT` after the positive source and after the negative source. It is `T_LONG` after gate-high, after bias and after gate-low. After the last of these waits the reference goes off and the block is idle.
- R8: If a start condition is lost during power-up, power-down begins from the rails already on, with the same order and waits.
- R9: A power-down always runs to completion, even if the start conditions return. If they are present when it completes, a new power-up begins on the next clock edge.
- R10: An over-temperature fault, or a fall of the filtered supply-good level, forces the same power-down as a fall of enable.
- R11: At most one rail enable changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| chip_en_i | input | 1 | Chip enable |
| supply_ok_i | input | 1 | Raw input-supply-good level (above undervoltage threshold) |
| therm_fault_i | input | 1 | Over-temperature fault level |
| ref_en_o | output | 1 | Internal reference enable |
| rail_en_o | output | 5 | Rail enables, mapping as in R4 |
| all_up_o | output | 1 | All rails on and settled |
| busy_o | output | 1 | Power-up or power-down running |

## Verification
A change of enable or fault is due at the rail outputs on the second clock edge after the change. A supply-good fall is due one edge after the tick on which the filter flips, and then one more edge later. A countdown that ends on a tick acts on the edge after that tick. The bench drives each tick as a one-cycle pulse followed by one idle cycle, and samples on the falling edge after the idle cycle. Each step of the up and down sweeps is therefore checked exactly in the cycle where the arithmetic model puts it. Trigger checks wait exactly the two edges that R6 gives.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int T_REF     = 1,
  parameter int T_STEP    = 3,
  parameter int T_SHORT   = 10,
  parameter int T_LONG    = 1500,
  parameter int DEB_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       chip_en_i,
  input  logic       supply_ok_i,
  input  logic       therm_fault_i,
  output logic       ref_en_o,
  output logic [4:0] rail_en_o,
  output logic       all_up_o,
  output logic       busy_o
);
  localparam int M_UP = (T_REF > T_STEP) ? T_REF : T_STEP;
  localparam int M_DN = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
  localparam int M_ALL = (M_UP > M_DN) ? M_UP : M_DN;
  localparam int CW = $clog2(M_ALL + 1);
  localparam int DW = $clog2(DEB_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_ON, S_DN} st_t;

  st_t           st;
  logic [2:0]    lvl;
  logic [CW-1:0] cnt;
  logic          ok_f;
  logic [DW-1:0] dcnt;

  wire go = chip_en_i & ok_f & ~therm_fault_i;

  function automatic logic [CW-1:0] dn_gap(input logic [2:0] r);
    case (r)
      3'd4, 3'd1: dn_gap = CW'(T_SHORT);
      default:    dn_gap = CW'(T_LONG);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_f <= 1'b0;
      dcnt <= '0;
    end else if (supply_ok_i == ok_f) begin
      dcnt <= '0;
    end else if (ms_tick) begin
      if (dcnt == DW'(DEB_TICKS - 1)) begin
        ok_f <= supply_ok_i;
        dcnt <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      lvl <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st  <= S_UP;
          cnt <= CW'(T_REF);
        end
        S_UP: if (!go) begin
          st  <= S_DN;
          cnt <= '0;
        end else if (cnt == '0) begin
          lvl <= lvl + 3'd1;
          cnt <= CW'(T_STEP);
          if (lvl == 3'd4) st <= S_ON;
        end else if (ms_tick) begin
          cnt <= cnt - 1'b1;
        end
        S_ON: if (!go) begin
          st  <= S_DN;
          cnt <= '0;
        end
        default: if (cnt != '0) begin
          if (ms_tick) cnt <= cnt - 1'b1;
        end else if (lvl != 3'd0) begin
          lvl <= lvl - 3'd1;
          cnt <= dn_gap(lvl - 3'd1);
        end else begin
          st <= S_IDLE;
        end
      endcase
    end
  end

  for (genvar i = 0; i < 5; i++) begin : g_rail
    assign rail_en_o[i] = (lvl > 3'(i));
  end

  assign ref_en_o = (st != S_IDLE);
  assign all_up_o = (st == S_ON);
  assign busy_o   = (st == S_UP) || (st == S_DN);
endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chip_en_i,
  input logic       therm_fault_i,
  input logic       ref_en_o,
  input logic [4:0] rail_en_o,
  input logic       all_up_o,
  input logic       busy_o
);
  // R11
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en_o ^ $past(rail_en_o)) <= 1);

  // R4
  up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rail_en_o & ~$past(rail_en_o))) |-> (rail_en_o == {$past(rail_en_o[3:0]), 1'b1}));

  // R6
  dn_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~rail_en_o & $past(rail_en_o))) |-> (rail_en_o == ($past(rail_en_o) >> 1)));

  // R4
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rail_en_o) |-> ref_en_o);

  // R5
  all_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_up_o |-> (rail_en_o == 5'h1f) && !busy_o);

  // R10
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_fault_i && all_up_o) |=> !all_up_o);

  // R2
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en_i && !ref_en_o) |=> !ref_en_o);
endmodule

bind rail_sequencer rail_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .therm_fault_i(therm_fault_i),
  .ref_en_o(ref_en_o), .rail_en_o(rail_en_o), .all_up_o(all_up_o), .busy_o(busy_o)
);

// File: tb/rail_sequencer_tb_top.sv
module rail_sequencer_tb_top;
  localparam int TR = 2, TS = 3, TSH = 2, TL = 5, DB = 2;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic chip_en_i = 1'b0, supply_ok_i = 1'b0, therm_fault_i = 1'b0;
  logic ref_en_o, all_up_o, busy_o;
  logic [4:0] rail_en_o;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  rail_sequencer #(.T_REF(TR), .T_STEP(TS), .T_SHORT(TSH), .T_LONG(TL), .DEB_TICKS(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .chip_en_i(chip_en_i),
    .supply_ok_i(supply_ok_i), .therm_fault_i(therm_fault_i), .ref_en_o(ref_en_o),
    .rail_en_o(rail_en_o), .all_up_o(all_up_o), .busy_o(busy_o));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int lvl, input logic rf, input logic bz, input logic up);
    logic [8:0] got, exp;
    got = {rail_en_o, ref_en_o, busy_o, all_up_o, 1'b0};
    exp = {5'((1 << lvl) - 1), rf, bz, up, 1'b0};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s rails/ref/busy/up actual=%b expected=%b", tag, got[8:1], exp[8:1]);
    end
  endtask

  function automatic int gap(input int r);
    return (r == 4 || r == 1) ? TSH : TL;
  endfunction

  // R4 R5: sweep from entry into power-up until all rails on
  task automatic run_up(input string tag);
    for (int m = 1; m <= TR + 4 * TS; m++) begin
      int e;
      tick();
      e = (m < TR) ? 0 : 1 + (m - TR) / TS;
      if (e > 5) e = 5;
      chk(tag, e, 1'b1, e < 5, e == 5);
    end
  endtask

  // R7 R8: rails at level r observed; walk the remaining gaps
  task automatic run_down(input string tag, input int from, input bit restart_en);
    for (int r = from; r >= 0; r--) begin
      for (int k = 1; k <= gap(r); k++) begin
        if (restart_en && r == 0 && k == 1) chip_en_i = 1'b1;
        tick();
        if (k < gap(r)) chk(tag, r, 1'b1, 1'b1, 1'b0);
        else if (r > 0) chk(tag, r - 1, 1'b1, 1'b1, 1'b0);
        else chk(tag, 0, 1'b0, 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    cyc(2);
    chk("R1 reset", 0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 after reset", 0, 1'b0, 1'b0, 1'b0);
    chip_en_i = 1'b1;
    supply_ok_i = 1'b1;
    tick();
    chk("R3 filter holds start", 0, 1'b0, 1'b0, 1'b0);
    tick();
    chk("R2 start", 0, 1'b1, 1'b1, 1'b0);
    run_up("R4 first power-up");

    chip_en_i = 1'b0;
    cyc(2);
    chk("R6 enable drop", 4, 1'b1, 1'b1, 1'b0);
    run_down("R7 full power-down", 4, 1'b0);
    cyc(3);
    chk("R2 idle without enable", 0, 1'b0, 1'b0, 1'b0);

    chip_en_i = 1'b1;
    cyc(1);
    chk("R2 restart", 0, 1'b1, 1'b1, 1'b0);
    repeat (TR + TS) tick();
    chk("R4 partial up", 2, 1'b1, 1'b1, 1'b0);
    chip_en_i = 1'b0;
    cyc(2);
    chk("R8 abort", 1, 1'b1, 1'b1, 1'b0);
    run_down("R8 R9 abort power-down", 1, 1'b1);
    cyc(1);
    chk("R9 restart after completion", 0, 1'b1, 1'b1, 1'b0);
    run_up("R4 second power-up");

    therm_fault_i = 1'b1;
    cyc(2);
    chk("R10 fault drop", 4, 1'b1, 1'b1, 1'b0);
    run_down("R10 fault power-down", 4, 1'b0);
    repeat (3) tick();
    chk("R2 fault blocks start", 0, 1'b0, 1'b0, 1'b0);
    therm_fault_i = 1'b0;
    cyc(1);
    chk("R2 start after fault clears", 0, 1'b1, 1'b1, 1'b0);
    run_up("R4 third power-up");

    supply_ok_i = 1'b0;
    tick();
    supply_ok_i = 1'b1;
    repeat (3) tick();
    chk("R3 glitch ignored", 5, 1'b1, 1'b0, 1'b1);
    supply_ok_i = 1'b0;
    tick();
    chk("R3 one tick low", 5, 1'b1, 1'b0, 1'b1);
    tick();
    chk("R10 supply flip", 5, 1'b1, 1'b1, 1'b0);
    cyc(1);
    chk("R10 supply drop", 4, 1'b1, 1'b1, 1'b0);
    run_down("R10 supply power-down", 4, 1'b0);
    cyc(4);
    chk("R2 no supply idle", 0, 1'b0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule